// File: doc/BRIEF.md
# J1850 Type-1 In-Frame Response Transmitter

This block sends a one-byte type-1 in-frame response (IFR) on a variable-pulse-width serial bus. The response goes out in the response window of a frame that another node is still transmitting. Software first programs the received-byte count it expects and the node's physical address. It then arms the block with a single opcode write. From that point the block needs no further writes.

The block measures how long the bus has been passive since the last active period, which gives it the end-of-data (EOD) timing. When the minimum EOD time is reached, it checks the received-byte count and the receive error flags against its preconditions. If they are met, it starts at the nominal EOD time. It starts sooner if another node's active edge appears first, so that it locks onto that node's timing.

The transmission is a long active normalization pulse, then the address byte as eight alternating-level symbols, then a passive end-of-frame period. If another node drives the bus active while the block drives a passive data symbol, the block has lost arbitration. It then goes passive at once, raises a flag and an optional interrupt, and drops the response without retrying.

States: `S_IDLE` (waiting for the arming write), `S_ARMED` (armed, frame in progress), `S_WINDOW` (minimum EOD reached, waiting for a start point), `S_NB1` (normalization pulse), `S_DATA` (address bits), `S_EOF` (end-of-frame period).

Transitions:
- arm: `S_IDLE` → `S_ARMED`
- cancel (on `sof`): `S_ARMED` or `S_WINDOW` → `S_IDLE`
- reject (preconditions fail at EOD): `S_ARMED` → `S_IDLE`
- qualify: `S_ARMED` → `S_WINDOW`
- start (nominal or early): `S_WINDOW` → `S_NB1`
- first bit: `S_NB1` → `S_DATA`
- next bit: `S_DATA` → `S_DATA`
- last bit: `S_DATA` → `S_EOF`
- lose: `S_DATA` → `S_IDLE`
- finish: `S_EOF` → `S_IDLE`

Top module: `ifr1_responder`

## Requirements
- R1: After reset `tx_out` is 0 (passive), `tx_ready` is 1 and `lost_flag` is 0. A one-cycle `op_wr` with `op_code` equal to 4'h6 arms the block. It clears `tx_ready` and `lost_flag` in the next cycle. A write with any other code changes nothing.
- R2: An arming write is ignored, and `tx_ready` stays 1, if the bus has been passive (`bus_rx`=0) for at least EOD_MIN_US microseconds counting the cycle of the write.
- R3: In the cycle where the passive time reaches EOD_MIN_US, an armed block goes on only if `rx_byte_cnt` equals `req_count` and all five bits of `rx_err` are 0. Otherwise it drops the request, sends nothing, and sets `tx_ready` to 1 again.
- R4: A qualified block starts transmitting in the cycle after the passive time reaches EOD_NOM_US.
- R5: A qualified block that sees `bus_rx`=1 before the nominal time starts transmitting in the next cycle.
- R6: The response is a normalization pulse: `tx_out`=1 for LONG_US. It is followed by `phys_addr` (sampled at start) MSB first, each bit a symbol whose level alternates and starts passive. A bit lasts LONG_US when its value equals the symbol level (1 = active), and SHORT_US otherwise. Last comes EOF_US of passive level.
- R7: `tx_ready` returns to 1 in the first cycle of the normalization pulse.
- R8: If `bus_rx`=1 while the block drives a passive data symbol, the next cycle has `tx_out`=0 and `lost_flag`=1, plus a one-cycle `irq` if `irq_en` is 1. No retry follows.
- R9: `ifr_done` pulses for one cycle right after the last EOF cycle.
- R10: An `sof` pulse while armed or waiting for the start point drops the request. Nothing is sent, and `tx_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rx | input | 1 | Filtered bus level, 1 = active |
| sof | input | 1 | Start-of-frame pulse from the receive path |
| op_wr | input | 1 | Opcode write strobe |
| op_code | input | 4 | Opcode value; 4'h6 requests a type-1 IFR |
| req_count | input | 4 | Received-byte count the response requires |
| rx_byte_cnt | input | 4 | Bytes received so far in the current frame |
| rx_err | input | 5 | Invalid bit, invalid frame, transmit error, break, CRC error |
| phys_addr | input | 8 | Physical address byte to send |
| irq_en | input | 1 | Enables the lost-arbitration interrupt |
| tx_out | output | 1 | Bus drive, 1 = active |
| tx_ready | output | 1 | Ready for a new opcode |
| lost_flag | output | 1 | Arbitration was lost on the last response |
| irq | output | 1 | One-cycle lost-arbitration interrupt |
| ifr_done | output | 1 | One-cycle pulse when the response has completed |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the early start and the minimum EOD point. A competing node drives the bus active at a chosen passive time, just past the minimum EOD and before the nominal time. The bench checks that the start happens on exactly that edge and not at the nominal time.

The second pair is a competing node's active level and a passive data symbol of the block. The competitor goes active in the middle of the first data bit. The bench checks that the loss, the flag, the interrupt and the silence afterwards all line up with the cycle in which the competitor appears.

A reference model rebuilds the expected bus waveform as a queue of levels and is compared with the outputs every clock.

// File: rtl/ifr1_pkg.sv
package ifr1_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_WINDOW,
        S_NB1,
        S_DATA,
        S_EOF
    } ifr_state_e;
endpackage

// File: rtl/ifr1_idle_meter.sv
// Counts consecutive passive bus cycles and flags the EOD points.
module ifr1_idle_meter #(
    parameter int MIN_CYC = 163,
    parameter int NOM_CYC = 200,
    parameter int W       = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rx,
    output logic eod_past,
    output logic eod_min,
    output logic eod_nom
);
    logic [W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     pcnt <= '0;
        else if (bus_rx)                pcnt <= '0;
        else if (pcnt != W'(NOM_CYC))   pcnt <= pcnt + 1'b1;
    end

    always_comb begin
        eod_past = !bus_rx && (pcnt >= W'(MIN_CYC - 1));
        eod_min  = !bus_rx && (pcnt == W'(MIN_CYC - 1));
        eod_nom  = !bus_rx && (pcnt == W'(NOM_CYC - 1));
    end
endmodule

// File: rtl/ifr1_sym_timer.sv
// Free-running symbol timer; restart zeroes it, last marks the final cycle.
module ifr1_sym_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic [W-1:0] len,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assign last = (cnt == len - 1'b1);
endmodule

// File: rtl/ifr1_responder.sv
module ifr1_responder
    import ifr1_pkg::*;
#(
    parameter int          TICKS_PER_US = 4,
    parameter int          EOD_MIN_US   = 163,
    parameter int          EOD_NOM_US   = 200,
    parameter int          SHORT_US     = 64,
    parameter int          LONG_US      = 128,
    parameter int          EOF_US       = 280,
    parameter int          OPW          = 4,
    parameter int          CNTW         = 4,
    parameter int          ERRW         = 5,
    parameter int          AW           = 8,
    parameter logic [3:0]  IFR1_OP      = 4'h6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_rx,
    input  logic            sof,
    input  logic            op_wr,
    input  logic [OPW-1:0]  op_code,
    input  logic [CNTW-1:0] req_count,
    input  logic [CNTW-1:0] rx_byte_cnt,
    input  logic [ERRW-1:0] rx_err,
    input  logic [AW-1:0]   phys_addr,
    input  logic            irq_en,
    output logic            tx_out,
    output logic            tx_ready,
    output logic            lost_flag,
    output logic            irq,
    output logic            ifr_done
);
    localparam int MIN_CYC  = EOD_MIN_US * TICKS_PER_US;
    localparam int NOM_CYC  = EOD_NOM_US * TICKS_PER_US;
    localparam int SHORT_CYC = SHORT_US * TICKS_PER_US;
    localparam int LONG_CYC = LONG_US * TICKS_PER_US;
    localparam int EOF_CYC  = EOF_US * TICKS_PER_US;
    localparam int MAXSYM   = (EOF_CYC > LONG_CYC) ? EOF_CYC : LONG_CYC;
    localparam int CW       = $clog2(MAXSYM + 1);
    localparam int PW       = $clog2(NOM_CYC + 1);
    localparam int BW       = $clog2(AW);

    ifr_state_e     state, nxt;
    logic [BW-1:0]  bit_idx;
    logic [AW-1:0]  addr_q;
    logic           eod_past, eod_min, eod_nom;
    logic           restart, sym_last;
    logic [CW-1:0]  sym_len;
    logic           arm, start, drop, lose, finish, bit_step;
    logic           rx_ok, cur_bit, lvl_act;

    ifr1_idle_meter #(.MIN_CYC(MIN_CYC), .NOM_CYC(NOM_CYC), .W(PW)) u_meter (
        .clk(clk), .rst_n(rst_n), .bus_rx(bus_rx),
        .eod_past(eod_past), .eod_min(eod_min), .eod_nom(eod_nom)
    );

    ifr1_sym_timer #(.W(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .len(sym_len), .last(sym_last)
    );

    assign rx_ok   = (rx_byte_cnt == req_count) && (rx_err == '0);
    assign cur_bit = addr_q[AW-1-int'(bit_idx)];
    assign lvl_act = bit_idx[0];

    always_comb begin
        unique case (state)
            S_NB1:   sym_len = CW'(LONG_CYC);
            S_DATA:  sym_len = (cur_bit == lvl_act) ? CW'(LONG_CYC) : CW'(SHORT_CYC);
            S_EOF:   sym_len = CW'(EOF_CYC);
            default: sym_len = CW'(LONG_CYC);
        endcase
    end

    // Transition logic
    always_comb begin
        nxt = state; restart = 1'b0; arm = 1'b0; start = 1'b0; drop = 1'b0;
        lose = 1'b0; finish = 1'b0; bit_step = 1'b0;
        unique case (state)
            S_IDLE:
                if (op_wr && op_code == OPW'(IFR1_OP) && !eod_past) begin
                    nxt = S_ARMED; arm = 1'b1;
                end
            S_ARMED:
                if (sof) begin
                    nxt = S_IDLE; drop = 1'b1;
                end else if (eod_min) begin
                    if (rx_ok) nxt = S_WINDOW;
                    else begin nxt = S_IDLE; drop = 1'b1; end
                end
            S_WINDOW:
                if (sof) begin
                    nxt = S_IDLE; drop = 1'b1;
                end else if (bus_rx || eod_nom) begin
                    nxt = S_NB1; start = 1'b1; restart = 1'b1;
                end
            S_NB1:
                if (sym_last) begin nxt = S_DATA; restart = 1'b1; end
            S_DATA:
                if (!tx_out && bus_rx) begin
                    nxt = S_IDLE; lose = 1'b1;
                end else if (sym_last) begin
                    restart = 1'b1; bit_step = 1'b1;
                    if (bit_idx == BW'(AW - 1)) nxt = S_EOF;
                end
            S_EOF:
                if (sym_last) begin nxt = S_IDLE; finish = 1'b1; end
            default: nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            bit_idx   <= '0;
            addr_q    <= '0;
            tx_ready  <= 1'b1;
            lost_flag <= 1'b0;
            irq       <= 1'b0;
            ifr_done  <= 1'b0;
        end else begin
            state    <= nxt;
            irq      <= lose && irq_en;
            ifr_done <= finish;
            if (arm)               tx_ready <= 1'b0;
            else if (start || drop) tx_ready <= 1'b1;
            if (arm)               lost_flag <= 1'b0;
            else if (lose)         lost_flag <= 1'b1;
            if (start) begin
                addr_q  <= phys_addr;
                bit_idx <= '0;
            end else if (bit_step) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            S_NB1:   tx_out = 1'b1;
            S_DATA:  tx_out = lvl_act;
            default: tx_out = 1'b0;
        endcase
    end

    assert_arm_clears_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && op_wr && op_code == OPW'(IFR1_OP) && !eod_past) |=> !tx_ready);

    assert_late_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && eod_past) |=> state != S_ARMED);

    assert_start_sets_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WINDOW && !sof && (bus_rx || eod_nom)) |=> (tx_ready && tx_out));

    assert_lost_goes_passive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && !tx_out && bus_rx) |=> (!tx_out && lost_flag && state == S_IDLE));

    assert_irq_implies_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> lost_flag);

    assert_done_after_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ifr_done) |-> ($past(state) == S_EOF && state == S_IDLE));

    assert_sof_cancels_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_ARMED || state == S_WINDOW) && sof) |=> (state == S_IDLE && tx_ready));
endmodule

// File: tb/sim_ifr1_responder.sv
`timescale 1ns/1ps
module sim_ifr1_responder;
    localparam int TPU = 1;
    localparam int MINC = 163 * TPU;
    localparam int NOMC = 200 * TPU;
    localparam int SHC  = 64 * TPU;
    localparam int LGC  = 128 * TPU;
    localparam int EFC  = 280 * TPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oth = 1'b0;
    logic sof = 1'b0, op_wr = 1'b0, irq_en = 1'b1;
    logic [3:0] op_code = 4'h0, req_count = 4'd3, rx_byte_cnt = 4'd3;
    logic [4:0] rx_err = 5'd0;
    logic [7:0] phys_addr = 8'hA5;
    logic tx_out, tx_ready, lost_flag, irq, ifr_done;
    logic bus_rx;

    int total = 0, bad = 0;
    bit finished = 0;
    int n_done = 0, n_irq = 0, n_act = 0;

    always #2.5 clk = ~clk;
    assign bus_rx = tx_out | oth;

    ifr1_responder #(.TICKS_PER_US(TPU)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_rx(bus_rx), .sof(sof), .op_wr(op_wr),
        .op_code(op_code), .req_count(req_count), .rx_byte_cnt(rx_byte_cnt),
        .rx_err(rx_err), .phys_addr(phys_addr), .irq_en(irq_en),
        .tx_out(tx_out), .tx_ready(tx_ready), .lost_flag(lost_flag),
        .irq(irq), .ifr_done(ifr_done)
    );

    // Reference model: waveform queue of (level + 2*phase), phase 1=NB1 2=data 3=EOF
    int q[$];
    int m_mode, m_pass, m_phase;
    bit m_tx, m_ready, m_lost, m_irq, m_done;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_mode = 0; m_pass = 0; m_phase = 0;
            m_tx = 0; m_ready = 1; m_lost = 0; m_irq = 0; m_done = 0;
        end else begin
            bit bus, past, mn, nm;
            bus  = m_tx | oth;
            past = !bus && (m_pass >= MINC - 1);
            mn   = !bus && (m_pass == MINC - 1);
            nm   = !bus && (m_pass == NOMC - 1);
            m_irq = 0; m_done = 0;
            case (m_mode)
                0: if (op_wr && op_code == 4'h6 && !past) begin
                       m_mode = 1; m_ready = 0; m_lost = 0;
                   end
                1: if (sof) begin m_mode = 0; m_ready = 1; end
                   else if (mn) begin
                       if (rx_byte_cnt == req_count && rx_err == 0) m_mode = 2;
                       else begin m_mode = 0; m_ready = 1; end
                   end
                2: if (sof) begin m_mode = 0; m_ready = 1; end
                   else if (bus || nm) begin
                       q.delete();
                       repeat (LGC) q.push_back(1 + 2);
                       for (int i = 7; i >= 0; i--) begin
                           int lvl, len;
                           lvl = (7 - i) % 2;
                           len = (int'(phys_addr[i]) == lvl) ? LGC : SHC;
                           repeat (len) q.push_back(lvl + 4);
                       end
                       repeat (EFC) q.push_back(6);
                       m_mode = 3; m_ready = 1;
                       begin int e; e = q.pop_front(); m_tx = e[0]; m_phase = e / 2; end
                   end
                default:
                   if (m_phase == 2 && !m_tx && oth) begin
                       q.delete(); m_mode = 0; m_lost = 1; m_irq = irq_en;
                       m_tx = 0; m_phase = 0;
                   end else if (q.size() == 0) begin
                       m_done = 1; m_mode = 0; m_tx = 0; m_phase = 0;
                   end else begin
                       int e; e = q.pop_front(); m_tx = e[0]; m_phase = e / 2;
                   end
            endcase
            m_pass = bus ? 0 : ((m_pass < NOMC) ? m_pass + 1 : NOMC);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison and event counters
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [4:0] a, e;
            a = {tx_out, tx_ready, lost_flag, irq, ifr_done};
            e = {m_tx, m_ready, m_lost, m_irq, m_done};
            chk(a == e, "R4 R5 R6 R7 R8 R9 per-cycle {tx,ready,lost,irq,done}", a, e);
            n_done += ifr_done; n_irq += irq; n_act += tx_out;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input logic [3:0] code);
        op_code = code; op_wr = 1'b1; cyc(1); op_wr = 1'b0;
    endtask

    task automatic clr();
        n_done = 0; n_irq = 0; n_act = 0;
    endtask

    function automatic int exp_act(input logic [7:0] a);
        int s; s = LGC;
        for (int i = 7; i >= 0; i--)
            if ((7 - i) % 2 == 1) s += a[i] ? LGC : SHC;
        return s;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1; total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(3);
        chk(tx_out == 0 && tx_ready == 1 && lost_flag == 0, "R1 reset state",
            {tx_out, tx_ready, lost_flag}, 3'b010);
        rst_n = 1'b1;
        cyc(2);

        // Normal nominal start
        clr(); oth = 1; arm(4'h6);
        chk(tx_ready == 0, "R1 ready cleared by arm", tx_ready, 0);
        cyc(40); oth = 0; cyc(1500);
        chk(n_done == 1, "R9 done pulse count", n_done, 1);
        chk(n_act == exp_act(8'hA5), "R6 active cycles A5", n_act, exp_act(8'hA5));
        chk(n_irq == 0 && lost_flag == 0, "R8 no loss", {n_irq, lost_flag}, 0);

        // Different address
        clr(); phys_addr = 8'h3C; oth = 1; arm(4'h6); cyc(40); oth = 0; cyc(1500);
        chk(n_done == 1, "R9 done pulse 3C", n_done, 1);
        chk(n_act == exp_act(8'h3C), "R6 active cycles 3C", n_act, exp_act(8'h3C));
        phys_addr = 8'hA5;

        // Wrong opcode
        clr(); oth = 1; arm(4'h5);
        chk(tx_ready == 1, "R1 other opcode ignored", tx_ready, 1);
        cyc(40); oth = 0; cyc(1500);
        chk(n_act == 0, "R1 other opcode sends nothing", n_act, 0);

        // Late arm after minimum EOD
        clr(); oth = 1; cyc(40); oth = 0; cyc(170); arm(4'h6);
        chk(tx_ready == 1, "R2 late arm ignored", tx_ready, 1);
        cyc(1500);
        chk(n_act == 0, "R2 late arm sends nothing", n_act, 0);

        // Error flag present
        clr(); rx_err = 5'b00100; oth = 1; arm(4'h6); cyc(40); oth = 0; cyc(1500);
        chk(n_act == 0 && n_done == 0, "R3 error blocks response", n_act, 0);
        chk(tx_ready == 1, "R3 ready restored after reject", tx_ready, 1);
        rx_err = 5'd0;

        // Count mismatch
        clr(); rx_byte_cnt = 4'd2; oth = 1; arm(4'h6); cyc(40); oth = 0; cyc(1500);
        chk(n_act == 0, "R3 count mismatch blocks response", n_act, 0);
        rx_byte_cnt = 4'd3;

        // Early start on competitor edge
        clr(); oth = 1; arm(4'h6); cyc(40); oth = 0; cyc(180);
        chk(tx_out == 0, "R5 still waiting before edge", tx_out, 0);
        oth = 1; cyc(1);
        chk(tx_out == 1 && tx_ready == 1, "R5 R7 start on early edge",
            {tx_out, tx_ready}, 2'b11);
        cyc(9); oth = 0; cyc(1500);
        chk(n_done == 1, "R5 early response completes", n_done, 1);
        chk(n_act == exp_act(8'hA5), "R5 early response waveform", n_act, exp_act(8'hA5));

        // Lost arbitration in first data bit
        clr(); oth = 1; arm(4'h6); cyc(40); oth = 0; cyc(335); oth = 1; cyc(1);
        chk(lost_flag == 1 && tx_out == 0, "R8 loss flagged and passive",
            {lost_flag, tx_out}, 2'b10);
        cyc(29); oth = 0;
        chk(n_irq == 1, "R8 interrupt raised", n_irq, 1);
        chk(n_act == LGC, "R8 only NB1 driven", n_act, LGC);
        cyc(2000);
        chk(n_act == LGC && n_done == 0, "R8 no retry", n_act, LGC);

        // SOF while armed
        clr(); oth = 1; arm(4'h6); cyc(20); sof = 1; cyc(1); sof = 0;
        chk(tx_ready == 1, "R10 sof drops request", tx_ready, 1);
        cyc(20); oth = 0; cyc(1500);
        chk(n_act == 0, "R10 nothing sent after sof", n_act, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule